// File: doc/BRIEF.md
# TLB Diagnostic Access Port

This block lets software read and write single entries of two translation buffers directly, with no lookup involved. The first buffer is small and fully associative, with 32 entries. The second is large and two-way set-associative. It is split into a section for 8 KB pages and a section for 4 MB pages, with 512 sets per way in each section. A request carries an 18-bit access address, a write enable, and, for writes, the entry's tag, data and lock bit. The block decodes the address into a target buffer, an entry index, a way and a page-size section, then performs the access on plain register arrays.

How an index maps onto the large buffer depends on a 2-bit mode, which is sampled in the same cycle as the request. Some modes leave ranges unmapped. Reads of those ranges return zero, and writes to them are dropped. Each entry stores an even parity bit over its tag and data. An address flag can plant a wrong parity bit on a write, so that error handling elsewhere can be exercised. Any entry written into the large buffer has its lock bit stored as zero.

Read results appear one clock after the request, together with a valid strobe and a flag that reports a parity mismatch.

Top module: `tlbdiag_port`

## Requirements
- R1: Address bits 17:16 pick the target: 00 is the small buffer and 10 is the large buffer. Codes 01 and 11 are reserved. A read with a reserved code returns all-zero fields, and a write with a reserved code changes no entry.
- R2: For the small buffer, only the low 5 bits of the index (address bits 7:3) pick the entry. Index bits 10:5 are ignored.
- R3: A write with address bit 15 set stores the entry with inverted parity, and a later read of that entry shows rd_perr high. After a normal write, rd_perr is low. Bit 15 has no effect on a read.
- R4: In mode 00, large-buffer indices 0-511 select way 0 and indices 512-1023 select way 1 of the 8 KB section. Indices 1024-2047 read as zero and drop writes.
- R5: In mode 01, every large-buffer index reads as zero and drops writes.
- R6: In mode 10, index bit 10 selects the section (0 for 8 KB, 1 for 4 MB), index bit 9 selects the way, and bits 8:0 select the set.
- R7: In mode 11, indices 0-1023 and 1024-1279 / 1536-1791 map as in mode 10 and share the same storage. Indices 1280-1535 and 1792-2047 read as zero and drop writes.
- R8: A write to the large buffer stores the lock bit as zero. A write to the small buffer stores the lock bit as given.
- R9: Address bit 14 and bits 2:0 do not affect any access.
- R10: rd_valid is high for exactly the cycle after a read request is accepted and is never raised by a write. While rd_valid is low, all read fields are zero.
- R11: After reset, rd_valid is low and all read fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Large-buffer mapping mode, sampled with the request |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Access address (target, error flag, index) |
| wr_tag | input | 8 | Tag field to write |
| wr_data | input | 8 | Data field to write |
| wr_lock | input | 1 | Lock bit to write |
| rd_valid | output | 1 | Read result strobe |
| rd_tag | output | 8 | Tag read back |
| rd_data | output | 8 | Data read back |
| rd_lock | output | 1 | Lock bit read back |
| rd_perr | output | 1 | Stored parity does not match tag and data |

## Verification
Some behaviour can be checked on every cycle from the ports alone. The assertions do this for the read strobe timing, for the zero fields whenever no strobe is present, and for zero results from reserved targets, from mode 01 and from the mode 11 holes. Other behaviour needs a specific order of accesses and can only be shown by the bench's scenarios. That covers whether a dropped write really left the storage unchanged, the way and section mapping in each mode, storage shared between modes 10 and 11, index aliasing in the small buffer, lock clearing, and planted parity errors.

// File: rtl/tlbdiag_pkg.sv
// Package: shared widths, field positions and types for the TLB diagnostic port.
// Assumes an 18-bit access address whose field positions are fixed by software.
package tlbdiag_pkg;

    parameter int TAG_W  = 8;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 18;

    // Field positions that software encodes into the access address.
    localparam int SEL_LSB = 16;
    localparam int ERR_BIT = 15;
    localparam int IDX_LSB = 3;

    // Access target after decode.
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_SMALL = 2'd1,
        TGT_LARGE = 2'd2
    } tgt_e;

    // Large-buffer mapping modes.
    typedef enum logic [1:0] {
        MODE_8K_ONLY = 2'b00,
        MODE_OFF     = 2'b01,
        MODE_FULL    = 2'b10,
        MODE_HALF4M  = 2'b11
    } map_mode_e;

    // One stored buffer entry with its parity bit.
    typedef struct packed {
        logic              lock;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
        logic              par;
    } entry_t;

endpackage

// File: rtl/tlbdiag_decode.sv
// Module: tlbdiag_decode
// Purely combinational address decode. Turns the access address and mapping
// mode into a target, entry indices and the error-insert flag.
// Assumes: the large-buffer flat index equals the raw index, laid out as
// {section, way, set}. Unmapped ranges are reported as TGT_NONE.
module tlbdiag_decode
    import tlbdiag_pkg::*;
#(
    parameter int SET_W    = 9,
    parameter int SMALL_AW = 5,
    localparam int IDX_W   = SET_W + 2
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          mode,
    output tgt_e                tgt,
    output logic [SMALL_AW-1:0] small_idx,
    output logic [IDX_W-1:0]    large_idx,
    output logic                err_flag
);

    logic [1:0]       sel;
    logic [IDX_W-1:0] idx;
    logic             large_ok;

    assign sel       = addr[SEL_LSB +: 2];
    assign idx       = addr[IDX_LSB +: IDX_W];
    assign small_idx = idx[SMALL_AW-1:0];
    assign large_idx = idx;
    assign err_flag  = addr[ERR_BIT];

    // Decide whether the index falls inside a mapped large-buffer region.
    always_comb begin
        large_ok = 1'b0;
        if (map_mode_e'(mode) != MODE_OFF) begin
            if (!idx[IDX_W-1]) begin
                large_ok = 1'b1;
            end else begin
                case (map_mode_e'(mode))
                    MODE_FULL:   large_ok = 1'b1;
                    MODE_HALF4M: large_ok = !idx[SET_W-1];
                    default:     large_ok = 1'b0;
                endcase
            end
        end
    end

    // Select the target buffer from the target code.
    always_comb begin
        case (sel)
            2'b00:   tgt = TGT_SMALL;
            2'b10:   tgt = large_ok ? TGT_LARGE : TGT_NONE;
            default: tgt = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/tlbdiag_store.sv
// Module: tlbdiag_store
// Register-array entry storage with a write port and a registered read port.
// Parity is even over tag and data; the write can invert it on request.
// Assumes: at most one of write or read per cycle. The array is not reset,
// so entries are undefined until written.
module tlbdiag_store
    import tlbdiag_pkg::*;
#(
    parameter int AW     = 5,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [TAG_W-1:0]  wtag,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wlock,
    input  logic              wbad,
    output logic [TAG_W-1:0]  qtag,
    output logic [DATA_W-1:0] qdata,
    output logic              qlock,
    output logic              qperr
);

    entry_t mem [DEPTH];
    entry_t q;
    entry_t wentry;

    // Build the entry to store, with parity optionally corrupted.
    always_comb begin
        wentry.lock = wlock;
        wentry.tag  = wtag;
        wentry.data = wdata;
        wentry.par  = (^{wtag, wdata}) ^ wbad;
    end

    // Write the selected entry.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wentry;
    end

    // Register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[addr];
    end

    assign qtag  = q.tag;
    assign qdata = q.data;
    assign qlock = q.lock;
    assign qperr = (^{q.tag, q.data}) ^ q.par;

endmodule

// File: rtl/tlbdiag_port.sv
// Module: tlbdiag_port (top)
// Diagnostic read/write port onto a 32-entry fully associative buffer and a
// two-way, two-section set-associative buffer. Decodes the request, clears
// the lock bit on large-buffer writes, and returns read results one cycle
// after a read request.
// Assumes: single-cycle requests, mode sampled with the request, and read
// fields forced to zero whenever rd_valid is low.
module tlbdiag_port
    import tlbdiag_pkg::*;
#(
    parameter int SET_W    = 9,
    parameter int SMALL_AW = 5,
    localparam int IDX_W   = SET_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_lock,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_lock,
    output logic              rd_perr
);

    tgt_e                tgt;
    tgt_e                src_q;
    logic [SMALL_AW-1:0] small_idx;
    logic [IDX_W-1:0]    large_idx;
    logic                err_flag;
    logic                wr_req;
    logic                rd_req;
    logic                rd_valid_q;
    logic                lock_in;

    logic [TAG_W-1:0]    s_tag,  l_tag;
    logic [DATA_W-1:0]   s_data, l_data;
    logic                s_lock, l_lock, s_perr, l_perr;

    assign wr_req = req_valid &&  req_write;
    assign rd_req = req_valid && !req_write;

    tlbdiag_decode #(.SET_W(SET_W), .SMALL_AW(SMALL_AW)) u_decode (
        .addr      (req_addr),
        .mode      (mode),
        .tgt       (tgt),
        .small_idx (small_idx),
        .large_idx (large_idx),
        .err_flag  (err_flag)
    );

    // Lock bit kept for the small buffer, cleared for the large buffer.
    always_comb begin
        lock_in = (tgt == TGT_LARGE) ? 1'b0 : wr_lock;
    end

    tlbdiag_store #(.AW(SMALL_AW)) u_small (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_req && tgt == TGT_SMALL),
        .re    (rd_req && tgt == TGT_SMALL),
        .addr  (small_idx),
        .wtag  (wr_tag),
        .wdata (wr_data),
        .wlock (lock_in),
        .wbad  (err_flag),
        .qtag  (s_tag),
        .qdata (s_data),
        .qlock (s_lock),
        .qperr (s_perr)
    );

    tlbdiag_store #(.AW(IDX_W)) u_large (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_req && tgt == TGT_LARGE),
        .re    (rd_req && tgt == TGT_LARGE),
        .addr  (large_idx),
        .wtag  (wr_tag),
        .wdata (wr_data),
        .wlock (lock_in),
        .wbad  (err_flag),
        .qtag  (l_tag),
        .qdata (l_data),
        .qlock (l_lock),
        .qperr (l_perr)
    );

    // Track the read strobe and the source of the pending read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            src_q      <= TGT_NONE;
        end else begin
            rd_valid_q <= rd_req;
            src_q      <= rd_req ? tgt : TGT_NONE;
        end
    end

    // Route the read result, zero for reserved targets or no read.
    always_comb begin
        rd_valid = rd_valid_q;
        case (src_q)
            TGT_SMALL: {rd_tag, rd_data, rd_lock, rd_perr} = {s_tag, s_data, s_lock, s_perr};
            TGT_LARGE: {rd_tag, rd_data, rd_lock, rd_perr} = {l_tag, l_data, l_lock, l_perr};
            default:   {rd_tag, rd_data, rd_lock, rd_perr} = '0;
        endcase
    end

    AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid); // R10
    AST_NO_STROBE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid); // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_tag == '0 && rd_data == '0 && !rd_lock && !rd_perr)); // R10
    AST_RSVD_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[SEL_LSB]) |=>
        (rd_tag == '0 && rd_data == '0 && !rd_lock && !rd_perr)); // R1
    AST_MODE_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[SEL_LSB +: 2] == 2'b10 && mode == 2'b01) |=>
        (rd_tag == '0 && rd_data == '0 && !rd_lock && !rd_perr)); // R5
    AST_HALF4M_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[SEL_LSB +: 2] == 2'b10 && mode == 2'b11 &&
         req_addr[IDX_LSB + IDX_W - 1] && req_addr[IDX_LSB + SET_W - 1]) |=>
        (rd_tag == '0 && rd_data == '0 && !rd_lock && !rd_perr)); // R7

endmodule

// File: tb/tlbdiag_port_test.sv
module tlbdiag_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  wr_tag = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_lock = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_tag;
    logic [7:0]  rd_data;
    logic        rd_lock;
    logic        rd_perr;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    tlbdiag_port uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .wr_tag(wr_tag),
        .wr_data(wr_data), .wr_lock(wr_lock), .rd_valid(rd_valid),
        .rd_tag(rd_tag), .rd_data(rd_data), .rd_lock(rd_lock), .rd_perr(rd_perr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [17:0] mk(input logic [1:0] sel, input logic err, input logic [10:0] idx);
        return {sel, err, 1'b0, idx, 3'b000};
    endfunction

    task automatic chk(input string req, input logic v, input logic [7:0] t,
                       input logic [7:0] d, input logic l, input logic p);
        checks++;
        if (rd_valid !== v || rd_tag !== t || rd_data !== d || rd_lock !== l || rd_perr !== p) begin
            errors++;
            $display("FAIL %s: got v=%0b tag=%h data=%h lock=%0b perr=%0b exp v=%0b tag=%h data=%h lock=%0b perr=%0b",
                     req, rd_valid, rd_tag, rd_data, rd_lock, rd_perr, v, t, d, l, p);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic [17:0] a, input logic [7:0] t,
                      input logic [7:0] d, input logic l);
        @(negedge clk);
        mode = m; req_valid = 1; req_write = 1; req_addr = a;
        wr_tag = t; wr_data = d; wr_lock = l;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input string req, input logic [1:0] m, input logic [17:0] a,
                      input logic [7:0] t, input logic [7:0] d, input logic l, input logic p);
        @(negedge clk);
        mode = m; req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        chk(req, 1'b1, t, d, l, p);
        req_valid = 0;
    endtask

    task automatic t_reset;
        chk("R11 reset", 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_small;
        wr(2'b00, mk(2'b00, 0, 11'd5), 8'hA5, 8'h3C, 1'b1);
        rd("R8 small lock kept", 2'b00, mk(2'b00, 0, 11'd5), 8'hA5, 8'h3C, 1'b1, 1'b0);
        rd("R2 small upper index ignored", 2'b10, mk(2'b00, 0, 11'h7C5), 8'hA5, 8'h3C, 1'b1, 1'b0);
        rd("R9 bits 14 and 2:0 ignored", 2'b00, mk(2'b00, 0, 11'd5) | 18'h04007, 8'hA5, 8'h3C, 1'b1, 1'b0);
    endtask

    task automatic t_write_no_strobe;
        @(negedge clk);
        mode = 2'b00; req_valid = 1; req_write = 1; req_addr = mk(2'b00, 0, 11'd9);
        wr_tag = 8'h11; wr_data = 8'h22; wr_lock = 0;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk("R10 no strobe on write", 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_mode00;
        wr(2'b00, mk(2'b10, 0, 11'd3),   8'h13, 8'h31, 1'b1);
        wr(2'b00, mk(2'b10, 0, 11'd515), 8'h25, 8'h52, 1'b1);
        rd("R4 mode00 way0, R8 lock cleared", 2'b00, mk(2'b10, 0, 11'd3),   8'h13, 8'h31, 1'b0, 1'b0);
        rd("R4 mode00 way1", 2'b00, mk(2'b10, 0, 11'd515), 8'h25, 8'h52, 1'b0, 1'b0);
        wr(2'b10, mk(2'b10, 0, 11'd1024), 8'h44, 8'h55, 1'b0);
        wr(2'b00, mk(2'b10, 0, 11'd1024), 8'hEE, 8'hEE, 1'b0);
        rd("R4 mode00 upper half zero", 2'b00, mk(2'b10, 0, 11'd1024), 8'h00, 8'h00, 1'b0, 1'b0);
        rd("R4 mode00 upper write dropped", 2'b10, mk(2'b10, 0, 11'd1024), 8'h44, 8'h55, 1'b0, 1'b0);
    endtask

    task automatic t_mode01;
        rd("R5 mode01 read zero", 2'b01, mk(2'b10, 0, 11'd3), 8'h00, 8'h00, 1'b0, 1'b0);
        wr(2'b01, mk(2'b10, 0, 11'd3), 8'hDD, 8'hDD, 1'b0);
        rd("R5 mode01 write dropped", 2'b00, mk(2'b10, 0, 11'd3), 8'h13, 8'h31, 1'b0, 1'b0);
    endtask

    task automatic t_mode10;
        wr(2'b10, mk(2'b10, 0, 11'd1536), 8'h66, 8'h77, 1'b1);
        rd("R6 mode10 4M way0", 2'b10, mk(2'b10, 0, 11'd1024), 8'h44, 8'h55, 1'b0, 1'b0);
        rd("R6 mode10 4M way1", 2'b10, mk(2'b10, 0, 11'd1536), 8'h66, 8'h77, 1'b0, 1'b0);
        rd("R6 mode10 8K unaliased", 2'b10, mk(2'b10, 0, 11'd515), 8'h25, 8'h52, 1'b0, 1'b0);
    endtask

    task automatic t_mode11;
        rd("R7 mode11 4M way0 shared", 2'b11, mk(2'b10, 0, 11'd1024), 8'h44, 8'h55, 1'b0, 1'b0);
        rd("R7 mode11 4M way1 shared", 2'b11, mk(2'b10, 0, 11'd1536), 8'h66, 8'h77, 1'b0, 1'b0);
        rd("R7 mode11 8K", 2'b11, mk(2'b10, 0, 11'd3), 8'h13, 8'h31, 1'b0, 1'b0);
        wr(2'b10, mk(2'b10, 0, 11'd1280), 8'h88, 8'h99, 1'b0);
        wr(2'b11, mk(2'b10, 0, 11'd1280), 8'hBB, 8'hBB, 1'b0);
        rd("R7 mode11 hole reads zero", 2'b11, mk(2'b10, 0, 11'd1280), 8'h00, 8'h00, 1'b0, 1'b0);
        rd("R7 mode11 hole write dropped", 2'b10, mk(2'b10, 0, 11'd1280), 8'h88, 8'h99, 1'b0, 1'b0);
        rd("R7 mode11 upper hole zero", 2'b11, mk(2'b10, 0, 11'd1792), 8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_reserved_sel;
        wr(2'b00, mk(2'b01, 0, 11'd5), 8'hCC, 8'hCC, 1'b0);
        wr(2'b00, mk(2'b11, 0, 11'd5), 8'hCC, 8'hCC, 1'b0);
        rd("R1 sel01 read zero", 2'b00, mk(2'b01, 0, 11'd5), 8'h00, 8'h00, 1'b0, 1'b0);
        rd("R1 sel11 read zero", 2'b00, mk(2'b11, 0, 11'd5), 8'h00, 8'h00, 1'b0, 1'b0);
        rd("R1 reserved writes dropped", 2'b00, mk(2'b00, 0, 11'd5), 8'hA5, 8'h3C, 1'b1, 1'b0);
    endtask

    task automatic t_err_insert;
        wr(2'b00, mk(2'b00, 1, 11'd7), 8'h0F, 8'hF1, 1'b0);
        rd("R3 small planted parity error", 2'b00, mk(2'b00, 0, 11'd7), 8'h0F, 8'hF1, 1'b0, 1'b1);
        wr(2'b10, mk(2'b10, 1, 11'd700), 8'h5A, 8'h01, 1'b1);
        rd("R3 large planted parity error", 2'b10, mk(2'b10, 0, 11'd700), 8'h5A, 8'h01, 1'b0, 1'b1);
        rd("R3 flag ignored on read", 2'b00, mk(2'b00, 1, 11'd5), 8'hA5, 8'h3C, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_small();
        t_write_no_strobe();
        t_mode00();
        t_mode01();
        t_mode10();
        t_mode11();
        t_reserved_sel();
        t_err_insert();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got running exp finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule